// File: doc/BRIEF.md
# Credit-Counting Non-Preemptive Task Arbiter

This block sits beside one processor and decides which of its mapped tasks fires next. Each task holds a budget counted in firings, not in time, for the current replenishment interval. The arbiter walks the tasks in a fixed circular order. It hands the processor to the first task that is both ready and still holds credit. It then waits, without preemption, for a completion pulse, and charges that task one credit.

A task counts as ready when its input data is present and its output buffer has room. The surrounding logic folds those two conditions into one ready flag per task. Tasks that are not ready are passed over, so the processor is not left waiting on them.

An interval closes when the cycle timer reaches the programmed length, or earlier, as soon as every budget is spent. At that point every counter is reloaded from a staged credit register file. Budgets written during an interval therefore take effect only from the next interval. This keeps a budget change from cutting an interval short.

Top module: `credit_arbiter`

## Requirements
- R1: At each interval boundary every live counter is loaded from its staged credit value; a boundary coinciding with a completion pulse loads the staged value and the pulse charges nothing.
- R2: A task is granted only when its ready flag is high and its live counter is nonzero, both in the cycle before grant_valid rises.
- R3: A task whose ready flag is low is skipped, and the scan moves to the next index in ascending order, wrapping from N_TASKS-1 to 0.
- R4: While grant_valid is high and done is low, grant_valid stays high and grant_idx stays unchanged, whatever happens to the ready flags.
- R5: Each done pulse sampled while grant_valid is high lowers the granted task's live counter by one, so a task with staged credit c is granted exactly c times per interval when always ready.
- R6: When every live counter is zero the interval closes at once, with no wait for the timer, and the counters reload on the next clock edge.
- R7: When no early close occurs, the interval closes interval_len cycles after it began, and the counters reload.
- R8: A write on the credit port (cred_we high, cred_idx selecting the task, cred_val the budget) changes only the staged value; live counters keep their values until the next boundary.
- R9: With no task both ready and in credit, grant_valid stays low; the ready flags are re-examined every cycle.
- R10: After a completion the scan starts at the index following the task that just finished.
- R11: A done pulse while grant_valid is low has no effect on any counter.
- R12: After reset grant_valid is 0, grant_idx is 0, and all staged and live counters are 0.
- R13: grant_valid falls in the cycle after done is sampled, and a new grant appears at the earliest one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| task_ready | input | N_TASKS | Per-task ready flag (input present and output room) |
| done | input | 1 | One-cycle pulse: granted task finished its firing |
| cred_we | input | 1 | Staged credit write enable |
| cred_idx | input | IDX_W | Task whose staged credit is written |
| cred_val | input | CREDIT_W | Budget in firings per interval |
| interval_len | input | TIMER_W | Maximum interval length in cycles |
| grant_idx | output | IDX_W | Index of the task holding the processor |
| grant_valid | output | 1 | Processor is granted to grant_idx |

## Verification
The bench builds the arbiter with four tasks, 4-bit credits and an 8-bit timer, with the interval length driven to 200. Four tasks are enough for the scan to wrap and to skip tasks both for lack of credit and for lack of readiness. A 200-cycle interval is short enough that a reload driven by the timer can be awaited. It is also long enough that reloads caused by exhausted budgets are clearly separated from timer reloads. The bench also varies the completion latency, so that grants held over several cycles and back-to-back grants with one idle cycle both occur.

// File: rtl/credit_arb_pkg.sv
package credit_arb_pkg;

    typedef enum logic {
        ARB_SCAN = 1'b0,
        ARB_BUSY = 1'b1
    } arb_state_e;

endpackage

// File: rtl/interval_clock.sv
module interval_clock #(
    parameter int TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [TIMER_W-1:0] len,
    output logic               expire
);
    localparam int EXT_W = TIMER_W + 1;

    typedef struct packed {
        logic [TIMER_W-1:0] ticks;
    } clk_state_t;

    clk_state_t st_d, st_q;
    logic [EXT_W-1:0] ticks_next;

    always_comb begin
        ticks_next = {1'b0, st_q.ticks} + EXT_W'(1);
        expire     = (ticks_next >= {1'b0, len});
        st_d       = st_q;
        if (restart) begin
            st_d.ticks = '0;
        end else begin
            st_d.ticks = ticks_next[TIMER_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/credit_bank.sv
module credit_bank #(
    parameter int N_TASKS  = 4,
    parameter int CREDIT_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(N_TASKS)-1:0] wr_idx,
    input  logic [CREDIT_W-1:0]        wr_val,
    input  logic                       reload,
    input  logic                       dec_en,
    input  logic [$clog2(N_TASKS)-1:0] dec_idx,
    output logic [N_TASKS-1:0]         live_nz,
    output logic                       all_spent
);
    localparam int IDX_W = $clog2(N_TASKS);

    typedef struct packed {
        logic [N_TASKS-1:0][CREDIT_W-1:0] staged;
        logic [N_TASKS-1:0][CREDIT_W-1:0] live;
    } bank_state_t;

    bank_state_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en && (int'(wr_idx) < N_TASKS)) begin
            bank_d.staged[wr_idx] = wr_val;
        end
        if (reload) begin
            bank_d.live = bank_q.staged;
        end else if (dec_en && (bank_q.live[dec_idx] != '0)) begin
            bank_d.live[dec_idx] = bank_q.live[dec_idx] - CREDIT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    for (genvar t = 0; t < N_TASKS; t++) begin : g_nz
        assign live_nz[t] = (bank_q.live[t] != '0);
    end

    assign all_spent = ~|live_nz;

    logic unused_idx;
    assign unused_idx = ^{IDX_W{1'b0}};
endmodule

// File: rtl/circular_picker.sv
module circular_picker #(
    parameter int N_TASKS = 4
) (
    input  logic [N_TASKS-1:0]         eligible,
    input  logic [$clog2(N_TASKS)-1:0] start,
    output logic                       found,
    output logic [$clog2(N_TASKS)-1:0] pick
);
    localparam int IDX_W = $clog2(N_TASKS);

    always_comb begin
        found = 1'b0;
        pick  = start;
        for (int off = N_TASKS - 1; off >= 0; off--) begin
            int cand;
            cand = int'(start) + off;
            if (cand >= N_TASKS) begin
                cand = cand - N_TASKS;
            end
            if (eligible[cand]) begin
                found = 1'b1;
                pick  = IDX_W'(cand);
            end
        end
    end
endmodule

// File: rtl/credit_arbiter.sv
module credit_arbiter #(
    parameter int N_TASKS  = 4,
    parameter int CREDIT_W = 8,
    parameter int TIMER_W  = 16,
    localparam int IDX_W   = $clog2(N_TASKS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_TASKS-1:0]  task_ready,
    input  logic                done,
    input  logic                cred_we,
    input  logic [IDX_W-1:0]    cred_idx,
    input  logic [CREDIT_W-1:0] cred_val,
    input  logic [TIMER_W-1:0]  interval_len,
    output logic [IDX_W-1:0]    grant_idx,
    output logic                grant_valid
);
    import credit_arb_pkg::*;

    typedef struct packed {
        arb_state_e       state;
        logic [IDX_W-1:0] owner;
        logic [IDX_W-1:0] scan_from;
    } arb_state_t;

    arb_state_t arb_d, arb_q;

    logic [N_TASKS-1:0] live_nz;
    logic               all_spent;
    logic               expire;
    logic               reload;
    logic [N_TASKS-1:0] eligible;
    logic               pick_found;
    logic [IDX_W-1:0]   pick_idx;
    logic               charge;

    assign reload   = expire | all_spent;
    assign eligible = task_ready & live_nz;

    interval_clock #(
        .TIMER_W (TIMER_W)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (reload),
        .len     (interval_len),
        .expire  (expire)
    );

    credit_bank #(
        .N_TASKS  (N_TASKS),
        .CREDIT_W (CREDIT_W)
    ) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cred_we),
        .wr_idx    (cred_idx),
        .wr_val    (cred_val),
        .reload    (reload),
        .dec_en    (charge),
        .dec_idx   (arb_q.owner),
        .live_nz   (live_nz),
        .all_spent (all_spent)
    );

    circular_picker #(
        .N_TASKS (N_TASKS)
    ) pick_i (
        .eligible (eligible),
        .start    (arb_q.scan_from),
        .found    (pick_found),
        .pick     (pick_idx)
    );

    always_comb begin
        arb_d  = arb_q;
        charge = 1'b0;
        unique case (arb_q.state)
            ARB_SCAN: begin
                if (pick_found) begin
                    arb_d.state = ARB_BUSY;
                    arb_d.owner = pick_idx;
                end
            end
            ARB_BUSY: begin
                if (done) begin
                    charge      = 1'b1;
                    arb_d.state = ARB_SCAN;
                    if (int'(arb_q.owner) == N_TASKS - 1) begin
                        arb_d.scan_from = '0;
                    end else begin
                        arb_d.scan_from = arb_q.owner + IDX_W'(1);
                    end
                end
            end
            default: arb_d.state = ARB_SCAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arb_q.state     <= ARB_SCAN;
            arb_q.owner     <= '0;
            arb_q.scan_from <= '0;
        end else begin
            arb_q <= arb_d;
        end
    end

    assign grant_valid = (arb_q.state == ARB_BUSY);
    assign grant_idx   = arb_q.owner;
endmodule

// File: rtl/credit_arbiter_checker.sv
module credit_arbiter_checker #(
    parameter int N_TASKS = 4,
    localparam int IDX_W  = $clog2(N_TASKS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_TASKS-1:0] task_ready,
    input logic               done,
    input logic               grant_valid,
    input logic [IDX_W-1:0]   grant_idx,
    input logic [N_TASKS-1:0] live_nz
);
    logic [N_TASKS-1:0] elig_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elig_prev_q <= '0;
        end else begin
            elig_prev_q <= task_ready & live_nz;
        end
    end

    // R2: a fresh grant goes to a task that was ready and in credit
    a_r2_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> elig_prev_q[grant_idx]);

    // R4: no preemption while the firing is in progress
    a_r4_hold_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !done) |=> (grant_valid && $stable(grant_idx)));

    // R13: completion releases the processor on the next edge
    a_r13_release: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && done) |=> !grant_valid);

    // R9: nothing eligible means no grant
    a_r9_no_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && !(|(task_ready & live_nz))) |=> !grant_valid);
endmodule

bind credit_arbiter credit_arbiter_checker #(
    .N_TASKS (N_TASKS)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .task_ready  (task_ready),
    .done        (done),
    .grant_valid (grant_valid),
    .grant_idx   (grant_idx),
    .live_nz     (live_nz)
);

// File: tb/credit_arbiter_tb.sv
module credit_arbiter_tb_top;
    localparam int N_TASKS  = 4;
    localparam int CREDIT_W = 4;
    localparam int TIMER_W  = 8;
    localparam int IDX_W    = $clog2(N_TASKS);
    localparam time CLK_PERIOD = 10ns;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [N_TASKS-1:0]  task_ready = '0;
    logic                resp_done = 1'b0;
    logic                force_done = 1'b0;
    logic                done;
    logic                cred_we = 1'b0;
    logic [IDX_W-1:0]    cred_idx = '0;
    logic [CREDIT_W-1:0] cred_val = '0;
    logic [TIMER_W-1:0]  interval_len = 8'd200;
    logic [IDX_W-1:0]    grant_idx;
    logic                grant_valid;

    assign done = resp_done | force_done;

    always #(CLK_PERIOD / 2) clk = ~clk;

    credit_arbiter #(
        .N_TASKS  (N_TASKS),
        .CREDIT_W (CREDIT_W),
        .TIMER_W  (TIMER_W)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .task_ready   (task_ready),
        .done         (done),
        .cred_we      (cred_we),
        .cred_idx     (cred_idx),
        .cred_val     (cred_val),
        .interval_len (interval_len),
        .grant_idx    (grant_idx),
        .grant_valid  (grant_valid)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    int    grants_seen = 0;
    int    latency = 0;
    int    wait_left = 0;
    int    held_idx = 0;
    logic  prev_gv = 1'b0;
    logic  hold_bad = 1'b0;
    logic  sent_prev = 1'b0;
    int    exp_idx_q[$];
    string exp_tag_q[$];

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_grant(input int idx, input string tag);
        exp_idx_q.push_back(idx);
        exp_tag_q.push_back(tag);
    endtask

    // monitor and completion responder
    always @(negedge clk) begin
        resp_done = 1'b0;
        if (!rst_n) begin
            prev_gv   = 1'b0;
            sent_prev = 1'b0;
        end else begin
            if (sent_prev) begin
                check(!grant_valid, "R13 release after done", int'(grant_valid), 0);
            end
            if (grant_valid && !prev_gv) begin
                grants_seen++;
                if (exp_idx_q.size() == 0) begin
                    check(1'b0, "R2 unexpected grant", int'(grant_idx), -1);
                end else begin
                    int    e;
                    string t;
                    e = exp_idx_q.pop_front();
                    t = exp_tag_q.pop_front();
                    check(int'(grant_idx) == e, t, int'(grant_idx), e);
                end
                held_idx  = int'(grant_idx);
                wait_left = latency;
                hold_bad  = 1'b0;
            end else if (grant_valid && int'(grant_idx) != held_idx) begin
                hold_bad = 1'b1;
            end
            if (!grant_valid && prev_gv && !sent_prev) begin
                check(1'b0, "R4 grant dropped before done", 0, 1);
            end
            if (grant_valid) begin
                if (wait_left == 0) begin
                    resp_done = 1'b1;
                    if (latency > 0) begin
                        check(!hold_bad, "R4 grant held until done", int'(hold_bad), 0);
                    end
                end else begin
                    wait_left--;
                    if (wait_left == 2) begin
                        task_ready = ~task_ready;
                    end else if (wait_left == 1) begin
                        task_ready = ~task_ready;
                    end
                end
            end
            sent_prev = resp_done;
            prev_gv   = grant_valid;
        end
    end

    task automatic wait_grants(input int target, input int max_cycles, input string tag);
        for (int i = 0; i < max_cycles; i++) begin
            if (grants_seen >= target) break;
            @(negedge clk);
        end
        check(grants_seen >= target, tag, grants_seen, target);
    endtask

    task automatic check_idle(input int cycles, input string tag);
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (grant_valid) seen = 1'b1;
        end
        check(!seen, tag, int'(seen), 0);
    endtask

    task automatic write_credit(input int idx, input int val);
        @(negedge clk);
        cred_we  = 1'b1;
        cred_idx = IDX_W'(idx);
        cred_val = CREDIT_W'(val);
        @(negedge clk);
        cred_we  = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        check(grant_valid == 1'b0, "R12 grant_valid after reset", int'(grant_valid), 0);
        check(grant_idx == '0, "R12 grant_idx after reset", int'(grant_idx), 0);
        task_ready = '1;
        check_idle(10, "R12 no credit after reset");
        task_ready = '0;

        // first write makes task 0 live; the rest stay staged (R8)
        write_credit(0, 2);
        write_credit(1, 1);
        write_credit(2, 0);
        write_credit(3, 1);

        // S1: R8 staged, R5 exact count, R6 early close, R10, R3 skip of task 2 (no credit)
        expect_grant(0, "R5 first interval task0");
        expect_grant(0, "R8 staged credits not yet live");
        expect_grant(1, "R6 early reload then task1");
        expect_grant(3, "R3 task2 without credit skipped");
        expect_grant(0, "R10 wrap to task0");
        expect_grant(0, "R5 task0 second firing");
        expect_grant(1, "R1 reload restores task1");
        expect_grant(3, "R3 skip again");
        expect_grant(0, "R10 wrap again");
        expect_grant(0, "R5 task0 budget two");
        latency = 0;
        task_ready = '1;
        wait_grants(10, 100, "R6 ten grants well inside one timer interval");
        task_ready = '0;
        check_idle(5, "R9 nothing ready");

        // S2: new staged budgets; tasks 1 and 3 ready only
        write_credit(0, 3);
        write_credit(1, 3);
        write_credit(2, 3);
        write_credit(3, 3);
        expect_grant(1, "R3 task0 not ready skipped");
        expect_grant(3, "R8 old budget still live");
        task_ready = 4'b1010;
        wait_grants(12, 50, "R2 two grants on old budget");
        check_idle(20, "R8 new budget waits for boundary");
        for (int k = 0; k < 3; k++) begin
            expect_grant(1, "R7 timer reload task1");
            expect_grant(3, "R7 timer reload task3");
        end
        wait_grants(18, 400, "R7 timer expiry reloads counters");
        check_idle(5, "R9 ready tasks out of credit");

        // S3: long firings, ready toggled while busy
        latency = 6;
        for (int k = 0; k < 3; k++) begin
            expect_grant(0, "R10 resume after task3");
            expect_grant(2, "R4 alternate after long firing");
        end
        task_ready = 4'b0101;
        wait_grants(24, 200, "R4 six long firings");
        task_ready = '0;
        wait_grants(24, 20, "R4 settle");
        repeat (12) @(negedge clk);

        // S4: done pulses with no grant must not charge task2
        latency = 0;
        force_done = 1'b1;
        @(negedge clk);
        force_done = 1'b0;
        @(negedge clk);
        force_done = 1'b1;
        @(negedge clk);
        force_done = 1'b0;
        for (int k = 0; k < 3; k++) begin
            expect_grant(2, "R11 idle done ignored");
        end
        task_ready = 4'b0100;
        wait_grants(27, 50, "R11 full budget of task2 kept");
        check_idle(20, "R5 task2 stops at its budget");
        task_ready = '0;

        check(exp_idx_q.size() == 0, "R5 all expected grants seen", exp_idx_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL R5: watchdog expired, actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule